// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one N-bit integer by another over several clock cycles, one quotient bit per cycle, using the restoring method. The divisor magnitude is placed in the upper half of a double-width register and moves one place to the right on every iteration. A double-width remainder register starts from the zero-extended dividend magnitude. Each iteration tries a subtraction, keeps it when the difference is non-negative and discards it otherwise, and shifts the matching bit into the quotient from the right. The loop runs N+1 times.

A mode input selects signed or unsigned operands. In signed mode both operands are turned into magnitudes before the loop. Afterwards the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. A caller raises `start` for one cycle while the block is idle and then waits for the one-cycle `done` pulse. The quotient appears on the low result port and the remainder on the high result port. A zero divisor is reported through a flag.

Top module: `seqDivider`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done`, `divByZero`, `quoLo` and `remHi` are all zero.
- R2: A `start` seen while idle is accepted on that clock edge. `busy` then stays high until the result is ready. `done` goes high for exactly one cycle, on the (WIDTH+3)-th rising edge counting the accepting edge as the first, and `busy` is low while `done` is high.
- R3: A `start` seen while `busy` is high is ignored: the running division finishes with its original operands and produces a single `done` pulse.
- R4: With `signedMode` = 0 the operands are unsigned, `quoLo` = floor(dividend / divisor) and `remHi` = dividend mod divisor.
- R5: With `signedMode` = 1 the operands are two's complement. The magnitude of the quotient is |dividend| / |divisor| and its sign is negative exactly when the operand signs differ. The remainder has magnitude |dividend| mod |divisor| and the sign of the dividend (so -7/2 gives -3 remainder -1, and 7/-2 gives -3 remainder 1).
- R6: A zero divisor sets `divByZero` together with `done`. The quotient is then all ones and the remainder equals the dividend as given. The next division by a non-zero divisor clears the flag.
- R7: `quoLo`, `remHi` and `divByZero` change only in the cycle in which `done` is high, and hold their values otherwise.
- R8: In signed mode the most negative value divided by -1 yields the low WIDTH bits of the true quotient (only the top bit set) and remainder 0.
- R9: The internal remainder never grows during an iteration. At the end of a division by a non-zero divisor, its magnitude is below the divisor magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; sampled only while idle |
| signedMode | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | WIDTH | Dividend, captured when start is accepted |
| divisor | input | WIDTH | Divisor, captured when start is accepted |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| divByZero | output | 1 | Divisor was zero for the last result |
| quoLo | output | WIDTH | Quotient of the last division |
| remHi | output | WIDTH | Remainder of the last division |

## Verification
Random operand pairs in both modes cover every sign combination, so a wrong sign rule for the quotient or the remainder shows up quickly. Directed cases take on the narrow spots. Small divisors against large dividends exercise the long run of kept subtractions. A divisor larger than the dividend must give quotient zero and an untouched remainder. The most-negative-by-minus-one pair checks the magnitude path at its widest value. A zero divisor in both modes separates the override path from the normal loop. A second start fired mid-run, and inputs wiggled after completion, show that captured operands and held results cannot be disturbed.

// File: rtl/divPkg.sv
package divPkg;
  typedef struct packed {
    logic load;    // capture operands, initialise registers
    logic step;    // one restoring iteration
    logic finish;  // sign correction and output update
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;
endpackage

// File: rtl/divControl.sv
module divControl
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output divStrobes_t strb,
  output logic        busy,
  output logic        done
);
  localparam int ITERS = WIDTH + 1;
  localparam int CW = $clog2(ITERS + 1);
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  divState_t state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    strb.load   = (state == ST_IDLE) && start;
    strb.step   = (state == ST_RUN);
    strb.finish = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_RUN;
          iterCnt <= '0;
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: done lasts a single cycle
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: result is never flagged while still running
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R3: a running division is never restarted by start
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && iterCnt != LAST) |=> (state == ST_RUN && iterCnt == $past(iterCnt) + 1'b1));
endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strb,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             divByZero,
  output logic [WIDTH-1:0] quoLo,
  output logic [WIDTH-1:0] remHi
);
  localparam int DW = 2 * WIDTH;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [DW-1:0]    remReg, divReg;
  logic [WIDTH-1:0] quoReg, divMag, rawDividend;
  logic             negQuo, negRem, zeroDiv;

  logic [WIDTH-1:0] aMag, bMag, remLow, quoFix, remFix;
  logic             aNeg, bNeg;
  logic [DW:0]      trial;

  always_comb begin
    aNeg   = signedMode && dividend[WIDTH-1];
    bNeg   = signedMode && divisor[WIDTH-1];
    aMag   = aNeg ? (~dividend + ONE) : dividend;
    bMag   = bNeg ? (~divisor + ONE) : divisor;
    trial  = {1'b0, remReg} - {1'b0, divReg};
    remLow = remReg[WIDTH-1:0];
    quoFix = negQuo ? (~quoReg + ONE) : quoReg;
    remFix = negRem ? (~remLow + ONE) : remLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg      <= '0;
      divReg      <= '0;
      quoReg      <= '0;
      divMag      <= '0;
      rawDividend <= '0;
      negQuo      <= 1'b0;
      negRem      <= 1'b0;
      zeroDiv     <= 1'b0;
      divByZero   <= 1'b0;
      quoLo       <= '0;
      remHi       <= '0;
    end else begin
      if (strb.load) begin
        remReg      <= {{WIDTH{1'b0}}, aMag};
        divReg      <= {bMag, {WIDTH{1'b0}}};
        quoReg      <= '0;
        divMag      <= bMag;
        rawDividend <= dividend;
        negQuo      <= aNeg ^ bNeg;
        negRem      <= aNeg;
        zeroDiv     <= (divisor == '0);
      end
      if (strb.step) begin
        // a negative trial restores by keeping the old remainder
        if (trial[DW]) begin
          quoReg <= {quoReg[WIDTH-2:0], 1'b0};
        end else begin
          remReg <= trial[DW-1:0];
          quoReg <= {quoReg[WIDTH-2:0], 1'b1};
        end
        divReg <= divReg >> 1;
      end
      if (strb.finish) begin
        divByZero <= zeroDiv;
        quoLo     <= zeroDiv ? {WIDTH{1'b1}} : quoFix;
        remHi     <= zeroDiv ? rawDividend : remFix;
      end
    end
  end

  // R9: restoring never increases the partial remainder
  assert_rem_shrinks_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> remReg <= $past(remReg));
  // R9: final remainder lies below the divisor
  assert_rem_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !zeroDiv) |-> (remReg[DW-1:WIDTH] == '0 && remLow < divMag));
  // R6: zero-divisor flag always comes with an all-ones quotient
  assert_dbz_quot_R6: assert property (@(posedge clk) disable iff (!rstN)
    divByZero |-> (quoLo == {WIDTH{1'b1}}));
endmodule

// File: rtl/seqDivider.sv
module seqDivider
  import divPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             divByZero,
  output logic [WIDTH-1:0] quoLo,
  output logic [WIDTH-1:0] remHi
);
  divStrobes_t strb;

  divControl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strb(strb), .busy(busy), .done(done)
  );

  divDatapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor),
    .divByZero(divByZero), .quoLo(quoLo), .remHi(remHi)
  );

  // R7: results move only together with done
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quoLo) && $stable(remHi) && $stable(divByZero)));
endmodule

// File: tb/sim_seqDivider.sv
module sim_seqDivider;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic signedMode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic busy, done, divByZero;
  logic [W-1:0] quoLo, remHi;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  seqDivider #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .divByZero(divByZero), .quoLo(quoLo), .remHi(remHi)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                       output logic [W-1:0] q, output logic [W-1:0] r, output logic z);
    logic [W-1:0] am, bm, qm, rm;
    logic an, bn;
    an = s && a[W-1];
    bn = s && b[W-1];
    am = an ? -a : a;
    bm = bn ? -b : b;
    if (b == '0) begin
      q = '1; r = a; z = 1'b1;
    end else begin
      qm = am / bm;
      rm = am % bm;
      q = (an ^ bn) ? -qm : qm;
      r = an ? -rm : rm;
      z = 1'b0;
    end
  endtask

  // runs one division; disturb=1 fires a second start mid-run
  task automatic runDiv(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic s, input bit disturb);
    logic [W-1:0] eq, er;
    logic ez;
    int edges;
    int pulses;
    model(a, b, s, eq, er, ez);
    @(negedge clk);
    dividend = a; divisor = b; signedMode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    pulses = 0;
    check("R2 busy after start", {31'b0, busy}, 32'd1);
    while (!done && edges < 200) begin
      if (disturb && edges == 4) begin
        dividend = ~a; divisor = b + 32'd3; signedMode = ~s; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      edges++;
    end
    start = 1'b0;
    check("R2 latency", edges, W + 3);
    check("R2 busy low with done", {31'b0, busy}, 32'd0);
    check({req, " quotient"}, quoLo, eq);
    check({req, " remainder"}, remHi, er);
    check({req, " zero flag"}, {31'b0, divByZero}, {31'b0, ez});
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (done) pulses++;
    end
    check("R2/R3 single done pulse", pulses, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] ra, rb, hq, hr;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 flag", {31'b0, divByZero}, 32'd0);
    check("R1 quotient", quoLo, '0);
    check("R1 remainder", remHi, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", quoLo | remHi, '0);

    // directed cases
    runDiv("R4 7/2", 32'd7, 32'd2, 1'b0, 1'b0);
    runDiv("R5 -7/2", -32'sd7, 32'd2, 1'b1, 1'b0);
    runDiv("R5 7/-2", 32'd7, -32'sd2, 1'b1, 1'b0);
    runDiv("R5 -7/-2", -32'sd7, -32'sd2, 1'b1, 1'b0);
    runDiv("R4 big/1", 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
    runDiv("R4 small/big", 32'd5, 32'hF000_0000, 1'b0, 1'b0);
    runDiv("R8 minneg/-1", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
    runDiv("R6 unsigned zero", 32'h1234_5678, 32'd0, 1'b0, 1'b0);
    runDiv("R6 signed zero", 32'h8765_4321, 32'd0, 1'b1, 1'b0);
    runDiv("R6 flag clears", 32'd100, 32'd9, 1'b0, 1'b0);
    runDiv("R3 start ignored", 32'd1000, 32'd7, 1'b0, 1'b1);

    // R7 results held while inputs change without start
    hq = quoLo; hr = remHi;
    for (int i = 0; i < 6; i++) begin
      dividend = $urandom; divisor = $urandom; signedMode = ~signedMode;
      @(negedge clk);
    end
    check("R7 quotient held", quoLo, hq);
    check("R7 remainder held", remHi, hr);

    // random mix
    for (int i = 0; i < 200; i++) begin
      ra = $urandom;
      rb = $urandom;
      if (i % 3 == 0) rb = rb >> ($urandom % 31);
      runDiv((i % 2 == 0) ? "R4 random" : "R5 random", ra, rb, i[0], 1'b0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule